// File: doc/BRIEF.md
# Suspend and Wake-Up Controller

This block runs the low-power suspend sequence of a host-side controller. It is clocked only by a slow always-on clock of nominally 100 kHz. While suspended it removes the enable of the main clocks. It also releases a bidirectional, active-low wake line, which an external pull-up then holds HIGH.

Three things bring the block out of suspend:
- a change of the downstream attach level, which covers both connect and disconnect;
- an active-low chip-select access;
- an external agent pulling the wake line LOW.

None of these makes the controller fully awake. The block first enters a provisional resume window, whose length is set by a 16-bit field of the power-down control word. If software sets the run bit while the window is open, the block stays in the running state. If the window runs out first, the block gates the clocks again and releases the wake line.

Software requests suspend with a one-tick request while the run bit is 0. All asynchronous inputs pass through a synchronizer on the always-on clock before the state logic uses them.

Top module: `susp_wake_ctrl`

## Requirements
- R1: After reset the block is running: `main_clk_en`=1, `wake_oe`=1 and `wake_o`=0, so the wake line is driven LOW.
- R2: A `suspend_req` pulse sampled with `cmd_run`=0 while running sets `main_clk_en`=0 and `wake_oe`=0 at that same edge. With `cmd_run`=1 the pulse has no effect.
- R3: While suspended, a HIGH wake line causes no resume. A LOW wake line causes a resume. During the first SYNC_STAGES ticks of each suspend period the wake line level is ignored.
- R4: While suspended, `cs_n_i`=0 causes a resume.
- R5: While suspended, either a rising or a falling change of `attach_i` causes a resume. A steady level causes none.
- R6: The first edge of a resume comes SYNC_STAGES+1 always-on edges after the edge that first samples the event. From that edge on, `main_clk_en`=1 and `wake_oe`=1.
- R7: Let N be the window field, taken from bits [31:16] of `pdc_wdata` when `pdc_wr`=1. With `cmd_run` held at 0, the resume lasts N+1 ticks. N=0 therefore ends it at the next tick.
- R8: After reset the window field is 1000, so a resume lasts 1001 ticks.
- R9: `cmd_run`=1 sampled at any edge of an open window, the last one included, keeps the block running past the window.
- R10: When the window expires with `cmd_run`=0, the block returns to suspend with `main_clk_en`=0 and `wake_oe`=0. Setting `cmd_run` after that edge does not wake it.
- R11: Bits [15:0] of `pdc_wdata` do not affect the window length.
- R12: Chip-select and attach activity seen while running causes no resume later, once the block is in suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Always-on slow clock |
| rst | input | 1 | Synchronous active-high reset |
| pdc_wr | input | 1 | Write strobe of the power-down control word |
| pdc_wdata | input | 32 | Power-down control word; bits [31:16] hold the resume window |
| cmd_run | input | 1 | Run bit of the command register |
| suspend_req | input | 1 | One-tick suspend request from software |
| attach_i | input | 1 | Asynchronous downstream attach level |
| cs_n_i | input | 1 | Asynchronous active-low chip select |
| wake_pin_i | input | 1 | Sensed level of the wake line |
| wake_o | output | 1 | Output value of the wake line (always LOW) |
| wake_oe | output | 1 | Output enable of the wake line driver |
| main_clk_en | output | 1 | Enable of the gated main clocks |

## Verification
The bench builds the block with its default parameters: SYNC_STAGES of 2 and a 16-bit window field with a reset value of 1000. The two-stage synchronizer makes the resume latency of three edges and the wake-line guard of two ticks visible as exact cycle counts. The 1000-tick default is short enough to measure completely as a 1001-tick window. The bench sweeps window fields 0 to 7 against every resume source, and it places the run bit on the last open edge and on the first edge after expiry.

// File: rtl/susp_pkg.sv
package susp_pkg;

    typedef enum logic [1:0] {
        PM_RUNNING   = 2'd0,
        PM_SUSPENDED = 2'd1,
        PM_RESUMING  = 2'd2
    } pm_state_e;

    // Synchronized resume sources, already qualified as events.
    typedef struct packed {
        logic attach_chg;
        logic cs_act;
        logic pin_low;
    } wake_src_t;

    localparam int unsigned WIN_WIDTH_DEF = 16;
    localparam int unsigned WIN_LSB_DEF   = 16;
    localparam int unsigned WIN_RESET_DEF = 1000;

    function automatic logic wake_hit(input wake_src_t src, input logic pin_armed);
        return src.attach_chg | src.cs_act | (src.pin_low & pin_armed);
    endfunction

endpackage

// File: rtl/susp_sync.sv
module susp_sync #(
    parameter int unsigned        WIDTH   = 1,
    parameter int unsigned        STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                chain[g] <= RST_VAL;
            end else if (g == 0) begin
                chain[g] <= d;
            end else begin
                chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/susp_wake_detect.sv
module susp_wake_detect
    import susp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      attach_i,
    input  logic      cs_n_i,
    input  logic      wake_pin_i,
    output wake_src_t src_o
);

    localparam int unsigned NSRC = 3;

    logic [NSRC-1:0] raw_vec;
    logic [NSRC-1:0] syn_vec;
    logic            attach_prev;

    // bit 2: attach level, bit 1: chip select (active low), bit 0: wake line
    assign raw_vec = {attach_i, cs_n_i, wake_pin_i};

    susp_sync #(
        .WIDTH  (NSRC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b011)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_vec),
        .q  (syn_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            attach_prev <= 1'b0;
        end else begin
            attach_prev <= syn_vec[2];
        end
    end

    always_comb begin
        src_o.attach_chg = syn_vec[2] ^ attach_prev;
        src_o.cs_act     = ~syn_vec[1];
        src_o.pin_low    = ~syn_vec[0];
    end

    // R5: an attach change event lasts exactly one tick for one level change
    a_r5_attach_single: assert property (@(posedge clk) disable iff (rst)
        src_o.attach_chg |=> (attach_prev == $past(syn_vec[2])));

endmodule

// File: rtl/susp_window_ctr.sv
module susp_window_ctr #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             dec,
    output logic             expired
);

    logic [WIDTH-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (dec) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

    // R7: loading captures the programmed window length
    a_r7_load_value: assert property (@(posedge clk) disable iff (rst)
        (load) |=> (remain == $past(load_val)));

    // R7: the counter never decrements below zero
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
        !(dec && expired && !load));

endmodule

// File: rtl/susp_wake_ctrl.sv
module susp_wake_ctrl
    import susp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned WIN_WIDTH   = WIN_WIDTH_DEF,
    parameter int unsigned WIN_LSB     = WIN_LSB_DEF,
    parameter int unsigned WIN_RESET   = WIN_RESET_DEF
) (
    input  logic        clk_aon,
    input  logic        rst,
    input  logic        pdc_wr,
    input  logic [31:0] pdc_wdata,
    input  logic        cmd_run,
    input  logic        suspend_req,
    input  logic        attach_i,
    input  logic        cs_n_i,
    input  logic        wake_pin_i,
    output logic        wake_o,
    output logic        wake_oe,
    output logic        main_clk_en
);

    localparam int unsigned AGE_W = $clog2(SYNC_STAGES + 1);
    localparam logic [AGE_W-1:0] AGE_ARM = AGE_W'(SYNC_STAGES);
    localparam logic [WIN_WIDTH-1:0] WIN_INIT = WIN_WIDTH'(WIN_RESET);

    pm_state_e            state_q, state_d;
    wake_src_t            src;
    logic [WIN_WIDTH-1:0] win_len;
    logic [AGE_W-1:0]     susp_age;
    logic                 pin_armed;
    logic                 win_load;
    logic                 win_dec;
    logic                 win_expired;
    logic                 unused_low;

    // Power-down control word: window field only, other bits ignored
    always_ff @(posedge clk_aon) begin
        if (rst) begin
            win_len <= WIN_INIT;
        end else if (pdc_wr) begin
            win_len <= pdc_wdata[WIN_LSB +: WIN_WIDTH];
        end
    end

    assign unused_low = ^pdc_wdata[WIN_LSB-1:0];

    susp_wake_detect #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_detect (
        .clk       (clk_aon),
        .rst       (rst),
        .attach_i  (attach_i),
        .cs_n_i    (cs_n_i),
        .wake_pin_i(wake_pin_i),
        .src_o     (src)
    );

    susp_window_ctr #(
        .WIDTH(WIN_WIDTH)
    ) u_window (
        .clk     (clk_aon),
        .rst     (rst),
        .load    (win_load),
        .load_val(win_len),
        .dec     (win_dec),
        .expired (win_expired)
    );

    // Ticks spent in the current suspend period, saturating; the wake line
    // still carries the driven LOW through the synchronizer until armed.
    always_ff @(posedge clk_aon) begin
        if (rst || state_q != PM_SUSPENDED) begin
            susp_age <= '0;
        end else if (susp_age < AGE_ARM) begin
            susp_age <= susp_age + 1'b1;
        end
    end

    assign pin_armed = (susp_age >= AGE_ARM);

    always_comb begin
        state_d  = state_q;
        win_load = 1'b0;
        win_dec  = 1'b0;
        unique case (state_q)
            PM_RUNNING: begin
                if (suspend_req && !cmd_run) begin
                    state_d = PM_SUSPENDED;
                end
            end
            PM_SUSPENDED: begin
                if (wake_hit(src, pin_armed)) begin
                    state_d  = PM_RESUMING;
                    win_load = 1'b1;
                end
            end
            PM_RESUMING: begin
                if (cmd_run) begin
                    state_d = PM_RUNNING;
                end else if (win_expired) begin
                    state_d = PM_SUSPENDED;
                end else begin
                    win_dec = 1'b1;
                end
            end
            default: state_d = PM_RUNNING;
        endcase
    end

    always_ff @(posedge clk_aon) begin
        if (rst) begin
            state_q <= PM_RUNNING;
        end else begin
            state_q <= state_d;
        end
    end

    assign main_clk_en = (state_q != PM_SUSPENDED);
    assign wake_oe     = (state_q != PM_SUSPENDED);
    assign wake_o      = 1'b0;

    // R2: a request with run clear enters suspend at the next edge
    a_r2_enter_suspend: assert property (@(posedge clk_aon) disable iff (rst)
        (state_q == PM_RUNNING && suspend_req && !cmd_run) |=> !main_clk_en && !wake_oe);

    // R2: a request with run set leaves the block running
    a_r2_run_blocks: assert property (@(posedge clk_aon) disable iff (rst)
        (state_q == PM_RUNNING && cmd_run) |=> (state_q == PM_RUNNING));

    // R3: with no qualified source the block stays suspended
    a_r3_stay_suspended: assert property (@(posedge clk_aon) disable iff (rst)
        (state_q == PM_SUSPENDED && !src.attach_chg && !src.cs_act && !(src.pin_low && pin_armed))
        |=> (state_q == PM_SUSPENDED));

    // R6: a resume is only ever entered from suspend
    a_r6_resume_origin: assert property (@(posedge clk_aon) disable iff (rst)
        $rose(state_q == PM_RESUMING) |-> ($past(state_q) == PM_SUSPENDED));

    // R9: run set during the window commits to running
    a_r9_commit: assert property (@(posedge clk_aon) disable iff (rst)
        (state_q == PM_RESUMING && cmd_run) |=> (state_q == PM_RUNNING) && main_clk_en);

    // R10: expiry with run clear falls back to suspend
    a_r10_fallback: assert property (@(posedge clk_aon) disable iff (rst)
        (state_q == PM_RESUMING && !cmd_run && win_expired) |=> !main_clk_en && !wake_oe);

    // R1: the wake line is never driven HIGH
    a_r1_drive_low: assert property (@(posedge clk_aon) disable iff (rst)
        wake_oe |-> !wake_o);

endmodule

// File: tb/susp_wake_ctrl_tb.sv
module susp_wake_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC_N     = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        pdc_wr;
    logic [31:0] pdc_wdata;
    logic        cmd_run;
    logic        suspend_req;
    logic        attach_i;
    logic        cs_n_i;
    logic        ext_low;
    logic        wake_pin;
    logic        wake_o;
    logic        wake_oe;
    logic        main_clk_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Wake line: driven by the block, else pulled up unless held low outside
    assign wake_pin = wake_oe ? wake_o : (ext_low ? 1'b0 : 1'b1);

    susp_wake_ctrl #(.SYNC_STAGES(SYNC_N)) dut_i (
        .clk_aon    (clk),
        .rst        (rst),
        .pdc_wr     (pdc_wr),
        .pdc_wdata  (pdc_wdata),
        .cmd_run    (cmd_run),
        .suspend_req(suspend_req),
        .attach_i   (attach_i),
        .cs_n_i     (cs_n_i),
        .wake_pin_i (wake_pin),
        .wake_o     (wake_o),
        .wake_oe    (wake_oe),
        .main_clk_en(main_clk_en)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_window(input logic [15:0] n, input logic [15:0] low);
        pdc_wr    = 1'b1;
        pdc_wdata = {n, low};
        tick();
        pdc_wr    = 1'b0;
        pdc_wdata = '0;
    endtask

    task automatic do_suspend();
        suspend_req = 1'b1;
        tick();
        suspend_req = 1'b0;
    endtask

    // src 0: wake line, 1: chip select, 2/3: attach toggle
    task automatic trigger(input int src);
        case (src)
            0: begin ext_low = 1'b1; tick(); ext_low = 1'b0; end
            1: begin cs_n_i = 1'b0; tick(); cs_n_i = 1'b1; end
            default: begin attach_i = ~attach_i; tick(); end
        endcase
    endtask

    task automatic wait_awake(output int lat);
        lat = 1;
        while (!main_clk_en && lat < 50) begin
            tick();
            lat++;
        end
    endtask

    task automatic count_high(output int hi);
        hi = 0;
        while (main_clk_en && hi < 5000) begin
            hi++;
            tick();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int lat;
        int hi;
        int ok;
        rst = 1'b1; pdc_wr = 1'b0; pdc_wdata = '0; cmd_run = 1'b0;
        suspend_req = 1'b0; attach_i = 1'b0; cs_n_i = 1'b1; ext_low = 1'b0;
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        check("R1", "clk_en", main_clk_en, 1);
        check("R1", "wake_oe", wake_oe, 1);
        check("R1", "wake_o", wake_o, 0);

        // R2: request ignored while run is set
        cmd_run = 1'b1;
        do_suspend();
        tick();
        check("R2", "run blocks suspend", main_clk_en, 1);
        cmd_run = 1'b0;

        // R12: activity while running leaves no pending resume
        attach_i = 1'b1; tick();
        cs_n_i = 1'b0; tick(); cs_n_i = 1'b1;
        repeat (5) tick();
        check("R12", "running ignores events", main_clk_en, 1);

        // R2 suspend entry
        do_suspend();
        check("R2", "clk_en gated", main_clk_en, 0);
        check("R2", "wake_oe released", wake_oe, 0);
        repeat (10) tick();
        check("R12", "no stale resume", main_clk_en, 0);

        // R3: HIGH line causes no resume
        ok = 1;
        for (int i = 0; i < 50; i++) begin
            tick();
            if (main_clk_en || wake_oe) ok = 0;
        end
        check("R3", "high line stays suspended", ok, 1);

        // R8 default window, via chip select (R4)
        trigger(1);
        wait_awake(lat);
        check("R4", "cs latency", lat, SYNC_N + 1);
        count_high(hi);
        check("R8", "default window ticks", hi, 1001);

        // R6/R7 sweep over window field and every source
        for (int n = 0; n < 8; n++) begin
            write_window(16'(n), 16'h0000);
            for (int src = 0; src < 4; src++) begin
                repeat (4) tick();
                trigger(src);
                wait_awake(lat);
                check((src == 0) ? "R3" : (src == 1) ? "R4" : "R5", "resume seen", main_clk_en, 1);
                check("R6", "resume latency", lat, SYNC_N + 1);
                count_high(hi);
                check("R7", "window ticks", hi, n + 1);
            end
        end

        // R11: low bits ignored
        write_window(16'd3, 16'hFFFF);
        repeat (4) tick();
        trigger(1);
        wait_awake(lat);
        count_high(hi);
        check("R11", "low bits ignored", hi, 4);

        // R9: run set on the last open edge commits
        write_window(16'd4, 16'h0000);
        repeat (4) tick();
        trigger(1);
        wait_awake(lat);
        repeat (4) tick();
        check("R9", "still in window", main_clk_en, 1);
        cmd_run = 1'b1;
        ok = 1;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (!main_clk_en) ok = 0;
        end
        check("R9", "committed past window", ok, 1);
        cmd_run = 1'b0;
        tick();
        do_suspend();
        check("R2", "suspend after commit", main_clk_en, 0);

        // R10: run set one edge late does not wake
        repeat (4) tick();
        trigger(1);
        wait_awake(lat);
        repeat (5) tick();
        check("R10", "fallback clk_en", main_clk_en, 0);
        check("R10", "fallback wake_oe", wake_oe, 0);
        cmd_run = 1'b1;
        repeat (10) tick();
        check("R10", "late run no wake", main_clk_en, 0);

        // R9: resume with run already set commits at once
        trigger(1);
        wait_awake(lat);
        repeat (10) tick();
        check("R9", "immediate commit", main_clk_en, 1);
        cmd_run = 1'b0;
        tick();

        // R3 guard: line held LOW from outside across suspend entry
        ext_low = 1'b1;
        do_suspend();
        check("R3", "guard edge 0", main_clk_en, 0);
        tick();
        check("R3", "guard edge 1", main_clk_en, 0);
        tick();
        check("R3", "guard edge 2", main_clk_en, 0);
        tick();
        check("R3", "armed wake", main_clk_en, 1);
        ext_low = 1'b0;
        count_high(hi);
        check("R7", "guard window ticks", hi, 5);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule